// File: doc/BRIEF.md
# Clock-Sampled Asynchronous SRAM Model

This block stands in for a byte-wide asynchronous static RAM when a memory controller is verified or prototyped. The RAM's control pins and address are sampled on every rising edge of a fast clock. The block decodes them with the usual truth table of such a part. Active-low chip select and active-high chip enable gate every access. Active-low write enable picks a write, and active-low output enable gates the data drivers. The tri-state data pins are split into a data input, a data output and a drive flag.

A write is active while chip select and write enable are low and chip enable is high. Any of these three controls may open or close it. The word is stored when the write closes, using the data seen in the last active sample, so no hold time is needed after the closing edge. Read data appears only after a parameterised number of sample clocks has passed since the most recent address change or enabling edge.

The block also checks the controller's timing, measured in sample clocks. A write pulse that is too short, too little recovery time between writes, and an address that moves during a write each set their own bit in a sticky violation register.

Top module: `sram_emu`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (deployed with ADDR_W=15 and DATA_W=8). A word written to an address is read back unchanged from that address, including address 0 and the highest address.
- R2: A write is active in a sample only when we_n_i=0, cs_n_i=0 and ce_i=1. The word is stored at the first sample where the write is no longer active, using the data from the last active sample. Data changed together with the closing control is ignored.
- R3: Writes complete correctly whichever control opens or closes them. This includes a write opened by chip select and closed by chip enable, and one opened by chip enable and closed by chip select.
- R4: dq_oe_o is high only while cs_n_i=0, ce_i=1, we_n_i=1, oe_n_i=0 and dvalid_o=1. The deselect, disable and write conditions drop it at once, without waiting for a clock edge. dout_o is zero whenever dq_oe_o is low.
- R5: While oe_n_i=1, dq_oe_o stays low and the read access keeps running. When oe_n_i returns low, the finished data is driven at once and no new access is started.
- R6: In read mode (cs_n_i=0, ce_i=1, we_n_i=1), dvalid_o rises at the ACC_CLKS-th clock edge after the edge that first samples a new address or the entry into read mode. An address change before that edge restarts the count.
- R7: viol_o bit 0 is set when a write ends after fewer than MIN_PULSE active samples.
- R8: viol_o bit 1 is set when a write begins after fewer than MIN_GAP inactive samples following the end of the previous write. The first write after reset is never flagged.
- R9: viol_o bit 2 is set when the address changes while a write is active. The word is then stored at the address sampled when the write began.
- R10: The violation bits are sticky and later correct writes do not clear them. Reset clears them and also clears dvalid_o, dq_oe_o and dout_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | ADDR_W | Word address |
| cs_n_i | input | 1 | Chip select, active low |
| ce_i | input | 1 | Chip enable, active high |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| din_i | input | DATA_W | Data pins as driven by the controller |
| dout_o | output | DATA_W | Data the RAM drives onto the pins |
| dq_oe_o | output | 1 | High when the RAM drives the data pins, low for high impedance |
| dvalid_o | output | 1 | Read access delay has elapsed for the current address |
| viol_o | output | 3 | Sticky violations: bit 0 short pulse, bit 1 short recovery, bit 2 address moved |

## Verification
The embedded properties check several rules on every cycle. A violation bit can only rise at the right point of a write: a short-pulse flag at its end, a recovery flag at its start, and an address flag while it is active. Violation bits never fall outside reset. Read data held as valid stays constant. A write commit and an active output drive never coincide. Only the directed scenarios can show the data actually stored and read back under each way of opening and closing a write. The same holds for the exact edge on which dvalid_o rises or restarts, for output enable leaving the access untouched, and for the stored word ignoring data changed together with the closing control.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

    // Sticky protocol violation flags; pulse_short is bit 0.
    typedef struct packed {
        logic addr_moved;
        logic gap_short;
        logic pulse_short;
    } viol_t;

    localparam int VIOL_W = 3;

endpackage

// File: rtl/sram_array.sv
module sram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/sram_wr_track.sv
module sram_wr_track
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 3,
    parameter int MIN_GAP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_act_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    output logic              commit_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [VIOL_W-1:0] viol_o
);
    localparam int LEN_W = $clog2(MIN_PULSE + 2);
    localparam int GAP_W = $clog2(MIN_GAP + 2);

    typedef struct packed {
        logic              active;
        logic [LEN_W-1:0]  len;
        logic [GAP_W-1:0]  gap;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        viol_t             viol;
    } trk_t;

    trk_t trk_d, trk_q;
    logic commit;

    always_comb begin
        trk_d  = trk_q;
        commit = 1'b0;
        if (wr_act_i) begin
            trk_d.data = din_i;
            if (!trk_q.active) begin
                trk_d.active = 1'b1;
                trk_d.len    = LEN_W'(1);
                trk_d.addr   = addr_i;
                if (trk_q.gap < GAP_W'(MIN_GAP)) begin
                    trk_d.viol.gap_short = 1'b1;
                end
            end else begin
                if (trk_q.len < LEN_W'(MIN_PULSE)) begin
                    trk_d.len = trk_q.len + LEN_W'(1);
                end
                if (addr_i != trk_q.addr) begin
                    trk_d.viol.addr_moved = 1'b1;
                end
            end
        end else if (trk_q.active) begin
            trk_d.active = 1'b0;
            trk_d.gap    = GAP_W'(1);
            commit       = 1'b1;
            if (trk_q.len < LEN_W'(MIN_PULSE)) begin
                trk_d.viol.pulse_short = 1'b1;
            end
        end else if (trk_q.gap < GAP_W'(MIN_GAP)) begin
            trk_d.gap = trk_q.gap + GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q     <= '0;
            trk_q.gap <= GAP_W'(MIN_GAP);
        end else begin
            trk_q <= trk_d;
        end
    end

    assign commit_o = commit;
    assign waddr_o  = trk_q.addr;
    assign wdata_o  = trk_q.data;
    assign viol_o   = trk_q.viol;

    // R9
    addr_flag_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trk_q.viol.addr_moved) |-> $past(trk_q.active));

    // R7
    pulse_flag_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trk_q.viol.pulse_short) |-> (!trk_q.active && $past(trk_q.active)));

    // R8
    gap_flag_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(trk_q.viol.gap_short) |-> (trk_q.active && !$past(trk_q.active)));

    // R10
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (trk_q.viol & $past(trk_q.viol)) == $past(trk_q.viol));

endmodule

// File: rtl/sram_rd_timer.sv
module sram_rd_timer #(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int ACC_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int CNT_W = $clog2(ACC_CLKS + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] prev_addr;
        logic              in_rd;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        logic [DATA_W-1:0] data;
    } rdt_t;

    rdt_t rdt_d, rdt_q;

    always_comb begin
        rdt_d           = rdt_q;
        rdt_d.prev_addr = addr_i;
        rdt_d.in_rd     = rd_mode_i;
        if (!rd_mode_i || !rdt_q.in_rd || addr_i != rdt_q.prev_addr) begin
            rdt_d.valid = 1'b0;
            rdt_d.cnt   = '0;
        end else if (!rdt_q.valid) begin
            rdt_d.cnt = rdt_q.cnt + CNT_W'(1);
            if (rdt_q.cnt == CNT_W'(ACC_CLKS - 1)) begin
                rdt_d.valid = 1'b1;
                rdt_d.data  = rdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdt_q <= '0;
        end else begin
            rdt_q <= rdt_d;
        end
    end

    assign valid_o = rdt_q.valid;
    assign data_o  = rdt_q.data;

    // R6
    valid_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rdt_q.valid) |-> $past(rd_mode_i));

    // R6
    held_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (rdt_q.valid && $past(rdt_q.valid)) |-> $stable(rdt_q.data));

endmodule

// File: rtl/sram_emu.sv
module sram_emu
    import sram_emu_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int ACC_CLKS  = 3,
    parameter int MIN_PULSE = 3,
    parameter int MIN_GAP   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] a_i,
    input  logic              cs_n_i,
    input  logic              ce_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              dq_oe_o,
    output logic              dvalid_o,
    output logic [VIOL_W-1:0] viol_o
);
    logic              wr_act;
    logic              rd_mode;
    logic              wr_commit;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] arr_rdata;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              drive;

    assign wr_act  = !cs_n_i && ce_i && !we_n_i;
    assign rd_mode = !cs_n_i && ce_i && we_n_i;

    sram_wr_track #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MIN_PULSE(MIN_PULSE),
        .MIN_GAP  (MIN_GAP)
    ) u_wr (
        .clk     (clk),
        .rst     (rst),
        .wr_act_i(wr_act),
        .addr_i  (a_i),
        .din_i   (din_i),
        .commit_o(wr_commit),
        .waddr_o (wr_addr),
        .wdata_o (wr_data),
        .viol_o  (viol_o)
    );

    sram_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_arr (
        .clk  (clk),
        .we   (wr_commit),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(a_i),
        .rdata(arr_rdata)
    );

    sram_rd_timer #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ACC_CLKS(ACC_CLKS)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_mode_i(rd_mode),
        .addr_i   (a_i),
        .rdata_i  (arr_rdata),
        .valid_o  (rd_valid),
        .data_o   (rd_data)
    );

    always_comb begin
        drive  = rd_valid && rd_mode && !oe_n_i;
        dout_o = drive ? rd_data : '0;
    end

    assign dq_oe_o  = drive;
    assign dvalid_o = rd_valid;

    // R4
    no_drive_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !dq_oe_o);

endmodule

// File: tb/sim_sram_emu.sv
module sim_sram_emu;
    localparam int AW  = 11;
    localparam int DW  = 8;
    localparam int ACC = 3;
    localparam int MP  = 3;
    localparam int MG  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] a_i = '0;
    logic          cs_n_i = 1'b1;
    logic          ce_i = 1'b1;
    logic          we_n_i = 1'b1;
    logic          oe_n_i = 1'b0;
    logic [DW-1:0] din_i = '0;
    logic [DW-1:0] dout_o;
    logic          dq_oe_o;
    logic          dvalid_o;
    logic [2:0]    viol_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    sram_emu #(
        .ADDR_W(AW), .DATA_W(DW), .ACC_CLKS(ACC), .MIN_PULSE(MP), .MIN_GAP(MG)
    ) u0 (
        .clk(clk), .rst(rst), .a_i(a_i), .cs_n_i(cs_n_i), .ce_i(ce_i),
        .we_n_i(we_n_i), .oe_n_i(oe_n_i), .din_i(din_i), .dout_o(dout_o),
        .dq_oe_o(dq_oe_o), .dvalid_o(dvalid_o), .viol_o(viol_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n_i = 1'b1; ce_i = 1'b1; we_n_i = 1'b1; oe_n_i = 1'b0;
        tick(2);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs_n_i = 1'b0; ce_i = 1'b1;
        a_i = a; din_i = d; we_n_i = 1'b0;
        tick(1);
        chk("R4", "no drive during write", dq_oe_o, 0);
        tick(MP - 1);
        we_n_i = 1'b1; din_i = ~d;   // R2: data changed with the closing edge
        tick(MG);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
        we_n_i = 1'b1; ce_i = 1'b1; oe_n_i = 1'b0; cs_n_i = 1'b1;
        tick(1);
        a_i = a; cs_n_i = 1'b0;
        tick(ACC);
        chk("R6", "valid before delay", dvalid_o, 0);
        tick(1);
        chk("R6", "valid after delay", dvalid_o, 1);
        chk(req, "drive flag", dq_oe_o, 1);
        chk(req, "read data", dout_o, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(2);
        chk("R10", "reset dout", dout_o, 0);
        chk("R10", "reset oe", dq_oe_o, 0);
        chk("R10", "reset valid", dvalid_o, 0);
        chk("R10", "reset viol", viol_o, 0);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_we_writes();
        wr_we(11'h000, 8'h5A);
        chk("R8", "first write after reset unflagged", viol_o, 0);
        wr_we(11'h7FF, 8'hC3);
        wr_we(11'h123, 8'h81);
        chk("R7", "legal pulses unflagged", viol_o, 0);
        rd_chk(11'h000, 8'h5A, "R1");
        rd_chk(11'h7FF, 8'hC3, "R1");
        rd_chk(11'h123, 8'h81, "R2");
    endtask

    task automatic t_cs_open_ce_close();
        a_i = 11'h044; din_i = 8'h3C;
        cs_n_i = 1'b1; ce_i = 1'b1; we_n_i = 1'b0;
        tick(1);
        cs_n_i = 1'b0;
        tick(MP);
        ce_i = 1'b0; din_i = 8'hFF;
        tick(1);
        we_n_i = 1'b1; ce_i = 1'b1;
        tick(MG);
        chk("R3", "cs/ce write unflagged", viol_o, 0);
        rd_chk(11'h044, 8'h3C, "R3");
    endtask

    task automatic t_ce_open_cs_close();
        a_i = 11'h055; din_i = 8'h96;
        cs_n_i = 1'b0; ce_i = 1'b0; we_n_i = 1'b0;
        tick(1);
        ce_i = 1'b1;
        tick(MP);
        cs_n_i = 1'b1; din_i = 8'h00;
        tick(1);
        we_n_i = 1'b1;
        tick(MG);
        chk("R3", "ce/cs write unflagged", viol_o, 0);
        rd_chk(11'h055, 8'h96, "R3");
    endtask

    task automatic t_access_restart();
        wr_we(11'h010, 8'h11);
        wr_we(11'h020, 8'h22);
        cs_n_i = 1'b1;
        tick(1);
        a_i = 11'h010; cs_n_i = 1'b0;
        tick(2);
        a_i = 11'h020;               // R6: restart before completion
        tick(ACC);
        chk("R6", "restart holds valid low", dvalid_o, 0);
        tick(1);
        chk("R6", "valid after restart", dvalid_o, 1);
        chk("R6", "data after restart", dout_o, 8'h22);
    endtask

    task automatic t_oe_and_select();
        oe_n_i = 1'b1;
        #1;
        chk("R5", "oe high no drive", dq_oe_o, 0);
        chk("R4", "dout zero when undriven", dout_o, 0);
        tick(1);
        chk("R5", "access kept under oe high", dvalid_o, 1);
        oe_n_i = 1'b0;
        #1;
        chk("R5", "drive on oe low", dq_oe_o, 1);
        chk("R5", "data on oe low", dout_o, 8'h22);
        cs_n_i = 1'b1;
        #1;
        chk("R4", "deselect drops drive", dq_oe_o, 0);
        cs_n_i = 1'b0; ce_i = 1'b0;
        #1;
        chk("R4", "disable drops drive", dq_oe_o, 0);
        ce_i = 1'b1;
        tick(1);
    endtask

    task automatic t_short_pulse();
        do_reset();
        cs_n_i = 1'b0; a_i = 11'h030; din_i = 8'h01; we_n_i = 1'b0;
        tick(1);
        we_n_i = 1'b1;
        tick(MG);
        chk("R7", "short pulse flag", viol_o, 3'b001);
        wr_we(11'h031, 8'h02);
        chk("R10", "flag sticky", viol_o, 3'b001);
        do_reset();
        chk("R10", "reset clears flags", viol_o, 0);
    endtask

    task automatic t_short_gap();
        do_reset();
        cs_n_i = 1'b0; a_i = 11'h032; din_i = 8'h05; we_n_i = 1'b0;
        tick(MP);
        we_n_i = 1'b1;
        tick(1);
        we_n_i = 1'b0;
        tick(MP);
        we_n_i = 1'b1;
        tick(MG);
        chk("R8", "short recovery flag", viol_o, 3'b010);
    endtask

    task automatic t_addr_move();
        do_reset();
        cs_n_i = 1'b0; a_i = 11'h040; din_i = 8'h77; we_n_i = 1'b0;
        tick(1);
        a_i = 11'h041;
        tick(MP - 1);
        we_n_i = 1'b1;
        tick(MG);
        chk("R9", "address moved flag", viol_o, 3'b100);
        rd_chk(11'h040, 8'h77, "R9");
    endtask

    initial begin
        t_reset();
        t_we_writes();
        t_cs_open_ce_close();
        t_ce_open_cs_close();
        t_access_restart();
        t_oe_and_select();
        t_short_pulse();
        t_short_gap();
        t_addr_move();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule